// File: doc/BRIEF.md
# Conversion Result Buffer with Temperature Slot

This block holds the results of a multichannel converter until a host reads them over a byte-wide serial read path. Voltage results go into a circular queue of `DEPTH` entries. A temperature result goes into its own single-entry register. When the host reads, the block hands out each stored result as two bytes, high byte first. The converter side never stalls: writing to a full queue overwrites its oldest entry, and writing a second temperature result before the first has been read replaces the first.

The block does not decode the serial protocol. A shifter outside the block asserts `rd_byte` for one cycle each time it has taken the byte on `rd_data`. It asserts `cs_fall` for one cycle when chip select goes active. The block keeps a byte pointer that says whether the high or the low byte of the current entry comes next. An entry is removed only after its low byte has been taken. A chip-select falling edge returns the pointer to the high byte of the oldest stored result. When the pointer is at a high byte and a temperature result is waiting, that result is read before any voltage result.

Top module: `conv_result_buffer`

## Requirements
- R1: After a synchronous reset, `q_empty` is 1, `q_full` is 0, `rd_data` is 0, no temperature result is pending and the pointer is at a high byte.
- R2: Voltage results are read in the order they were written. `q_full` is 1 exactly when `DEPTH` voltage results are stored, and `q_empty` is 1 exactly when none is stored.
- R3: A voltage write to a full queue, with no pop in the same cycle, drops the oldest entry and stores the new one. `q_full` stays 1.
- R4: Each result is read as two bytes. For `DATA_W`=12, the high byte is 4'b0000 followed by result bits [11:8], and the low byte, read next, is bits [7:0].
- R5: Reading a high byte removes nothing. Reading the low byte removes the entry, and the pointer moves to the high byte of the next entry.
- R6: When nothing is stored, `rd_data` is 8'h00. A `rd_byte` pulse in that state changes no state.
- R7: When the pointer is at a high byte and a temperature result is pending, the next two bytes read are that temperature result, ahead of every stored voltage result.
- R8: A temperature write while an unread temperature result is pending replaces it. Only the newer value is read, and it is read once.
- R9: A `cs_fall` pulse returns the pointer to the high byte of the oldest stored result. A `rd_byte` pulse in the same cycle is ignored.
- R10: If the entry whose low byte is next is overwritten in that cycle (a full-queue voltage write while a voltage entry is being read, or a temperature write while the temperature entry is being read), the pointer returns to the high byte and nothing is removed.
- R11: Temperature results pass through unchanged as two's complement at 1/8 degree per LSB. For example, 12'hF38 (-25.0 degrees) reads as 8'h0F then 8'h38.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Result write strobe |
| wr_is_temp | input | 1 | 1: the write is a temperature result; 0: the write is a voltage result |
| wr_data | input | DATA_W | Result value |
| rd_byte | input | 1 | The byte on `rd_data` has been taken; advance |
| cs_fall | input | 1 | Chip select went active; realign to a high byte |
| rd_data | output | BYTE_W | Next byte to shift out |
| q_empty | output | 1 | Voltage queue holds no result |
| q_full | output | 1 | Voltage queue holds DEPTH results |

## Verification
The assertions check, on every cycle, the properties that hold locally. A high byte always carries zero upper bits. An empty store reads as zero. Full and empty are never both set. A full queue stays full under a voltage write. A chip-select edge realigns the pointer. A high-byte read never removes an entry, and a low-byte read always removes one. Order-dependent behaviour needs the bench's scenarios: FIFO order across wrap-around, which entries are dropped on overflow, temperature priority and replacement, and the restart after an entry being read is overwritten. The bench also sweeps every 12-bit value through the queue to check the byte split.

// File: rtl/crb_pkg.sv
package crb_pkg;
   // Where the byte at the read port comes from
   typedef enum logic [1:0] {
      SRC_NONE = 2'd0,
      SRC_TEMP = 2'd1,
      SRC_VOLT = 2'd2
   } src_e;
endpackage

// File: rtl/crb_queue.sv
// Circular voltage-result queue; a push into a full queue advances the
// read side so the oldest entry is lost and the newest is kept.
module crb_queue #(
   parameter int W     = 12,
   parameter int DEPTH = 16
) (
   input  logic                         clk,
   input  logic                         rst,
   input  logic                         push,
   input  logic [W-1:0]                 din,
   input  logic                         pop,
   output logic [W-1:0]                 head,
   output logic                         empty,
   output logic                         full,
   output logic [$clog2(DEPTH+1)-1:0]   count
);
   localparam int PTR_W = $clog2(DEPTH);
   localparam int CNT_W = $clog2(DEPTH+1);

   logic [W-1:0]     mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic             do_pop, drop;

   // A power-of-two depth wraps by natural overflow; others compare.
   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
         assign wr_nxt = wr_ptr + 1'b1;
         assign rd_nxt = rd_ptr + 1'b1;
      end else begin : g_mod
         assign wr_nxt = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
         assign rd_nxt = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   assign empty  = (count == '0);
   assign full   = (count == CNT_W'(DEPTH));
   assign do_pop = pop & ~empty;
   assign drop   = push & full & ~do_pop;
   assign head   = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (push) mem[wr_ptr] <= din;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push) wr_ptr <= wr_nxt;
         if (do_pop || drop) rd_ptr <= rd_nxt;
         unique case ({push, do_pop})
            2'b10:   if (!full) count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end
endmodule

// File: rtl/crb_temp_slot.sv
// Single temperature result register; a load replaces any pending value.
module crb_temp_slot #(
   parameter int W = 12
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         load,
   input  logic [W-1:0] din,
   input  logic         clear,
   output logic [W-1:0] data,
   output logic         valid
);
   always_ff @(posedge clk) begin
      if (rst) begin
         data  <= '0;
         valid <= 1'b0;
      end else if (load) begin
         data  <= din;
         valid <= 1'b1;
      end else if (clear) begin
         valid <= 1'b0;
      end
   end
endmodule

// File: rtl/crb_reader.sv
// Byte pointer and output selection. The source is chosen at a high byte
// and held until the low byte is taken or the entry is overwritten.
module crb_reader
   import crb_pkg::*;
#(
   parameter int W      = 12,
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              rd_byte,
   input  logic              cs_fall,
   input  logic              temp_valid,
   input  logic [W-1:0]      temp_data,
   input  logic              temp_ovw,
   input  logic              q_empty,
   input  logic [W-1:0]      q_head,
   input  logic              volt_ovw,
   output logic [BYTE_W-1:0] rd_data,
   output logic              pop_q,
   output logic              clr_temp,
   output logic              hi_next
);
   logic         lock_temp;
   src_e         src;
   logic [W-1:0] sel_word;
   logic         abort, take;

   always_comb begin
      if (hi_next)
         src = temp_valid ? SRC_TEMP : (!q_empty ? SRC_VOLT : SRC_NONE);
      else
         src = lock_temp ? SRC_TEMP : SRC_VOLT;
   end

   always_comb begin
      unique case (src)
         SRC_TEMP: sel_word = temp_data;
         SRC_VOLT: sel_word = q_head;
         default:  sel_word = '0;
      endcase
   end

   assign rd_data  = hi_next ? BYTE_W'(sel_word >> BYTE_W) : sel_word[BYTE_W-1:0];

   assign abort    = !hi_next && (lock_temp ? temp_ovw : volt_ovw);
   assign take     = rd_byte && !cs_fall && !abort;
   assign pop_q    = take && !hi_next && !lock_temp;
   assign clr_temp = take && !hi_next && lock_temp;

   always_ff @(posedge clk) begin
      if (rst) begin
         hi_next   <= 1'b1;
         lock_temp <= 1'b0;
      end else if (cs_fall || abort) begin
         hi_next   <= 1'b1;
      end else if (take) begin
         if (hi_next) begin
            if (src != SRC_NONE) begin
               hi_next   <= 1'b0;
               lock_temp <= (src == SRC_TEMP);
            end
         end else begin
            hi_next <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/conv_result_buffer.sv
module conv_result_buffer #(
   parameter int DATA_W = 12,
   parameter int DEPTH  = 16,
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic              wr_is_temp,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_byte,
   input  logic              cs_fall,
   output logic [BYTE_W-1:0] rd_data,
   output logic              q_empty,
   output logic              q_full
);
   localparam int CNT_W = $clog2(DEPTH+1);

   initial begin
      assert (DATA_W > BYTE_W && DATA_W <= 2*BYTE_W)
         else $error("DATA_W must fit in two bytes and exceed one");
      assert (DEPTH >= 2) else $error("DEPTH must be at least 2");
   end

   logic              push_v, load_t, volt_ovw, temp_ovw;
   logic              pop_q, clr_temp, hi_next, temp_valid;
   logic [DATA_W-1:0] q_head, temp_data;
   logic [CNT_W-1:0]  q_count;

   assign push_v   = wr_en & ~wr_is_temp;
   assign load_t   = wr_en &  wr_is_temp;
   assign volt_ovw = push_v & q_full;
   assign temp_ovw = load_t & temp_valid;

   crb_queue #(.W(DATA_W), .DEPTH(DEPTH)) u_queue (
      .clk(clk), .rst(rst), .push(push_v), .din(wr_data), .pop(pop_q),
      .head(q_head), .empty(q_empty), .full(q_full), .count(q_count)
   );

   crb_temp_slot #(.W(DATA_W)) u_temp (
      .clk(clk), .rst(rst), .load(load_t), .din(wr_data), .clear(clr_temp),
      .data(temp_data), .valid(temp_valid)
   );

   crb_reader #(.W(DATA_W), .BYTE_W(BYTE_W)) u_reader (
      .clk(clk), .rst(rst), .rd_byte(rd_byte), .cs_fall(cs_fall),
      .temp_valid(temp_valid), .temp_data(temp_data), .temp_ovw(temp_ovw),
      .q_empty(q_empty), .q_head(q_head), .volt_ovw(volt_ovw),
      .rd_data(rd_data), .pop_q(pop_q), .clr_temp(clr_temp), .hi_next(hi_next)
   );
endmodule

// File: rtl/crb_checker.sv
module crb_checker #(
   parameter int DATA_W = 12,
   parameter int DEPTH  = 16,
   parameter int BYTE_W = 8
) (
   input logic                       clk,
   input logic                       rst,
   input logic                       wr_en,
   input logic                       wr_is_temp,
   input logic                       rd_byte,
   input logic                       cs_fall,
   input logic [BYTE_W-1:0]          rd_data,
   input logic                       q_empty,
   input logic                       q_full,
   input logic                       hi_next,
   input logic                       temp_valid,
   input logic [$clog2(DEPTH+1)-1:0] q_count
);
   AST_EMPTY_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
      (q_empty && !temp_valid && hi_next) |-> (rd_data == '0)); // R6
   AST_HIGH_BYTE_PADDED: assert property (@(posedge clk) disable iff (rst)
      hi_next |-> ((rd_data >> (DATA_W - BYTE_W)) == '0)); // R4
   AST_FULL_STAYS_FULL: assert property (@(posedge clk) disable iff (rst)
      (q_full && wr_en && !wr_is_temp) |=> q_full); // R3
   AST_NOT_FULL_AND_EMPTY: assert property (@(posedge clk) disable iff (rst)
      !(q_full && q_empty)); // R2
   AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
      (q_count <= ($clog2(DEPTH+1))'(DEPTH))); // R2
   AST_CS_REALIGN: assert property (@(posedge clk) disable iff (rst)
      cs_fall |=> hi_next); // R9
   AST_HIGH_READ_KEEPS: assert property (@(posedge clk) disable iff (rst)
      (hi_next && rd_byte && !wr_en) |=>
         (q_count == $past(q_count) && temp_valid == $past(temp_valid))); // R5
   AST_LOW_READ_POPS: assert property (@(posedge clk) disable iff (rst)
      (!hi_next && rd_byte && !cs_fall && !wr_en) |=>
         (hi_next && ((q_count < $past(q_count)) ||
                      (!temp_valid && $past(temp_valid))))); // R5
endmodule

bind conv_result_buffer crb_checker #(
   .DATA_W(DATA_W), .DEPTH(DEPTH), .BYTE_W(BYTE_W)
) u_chk (
   .clk(clk), .rst(rst), .wr_en(wr_en), .wr_is_temp(wr_is_temp),
   .rd_byte(rd_byte), .cs_fall(cs_fall), .rd_data(rd_data),
   .q_empty(q_empty), .q_full(q_full), .hi_next(hi_next),
   .temp_valid(temp_valid), .q_count(q_count)
);

// File: tb/sim_conv_result_buffer.sv
`timescale 1ns/1ps
module sim_conv_result_buffer;
   localparam int DW = 12;
   localparam int DP = 16;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          wr_en = 1'b0, wr_is_temp = 1'b0;
   logic [DW-1:0] wr_data = '0;
   logic          rd_byte = 1'b0, cs_fall = 1'b0;
   logic [7:0]    rd_data;
   logic          q_empty, q_full;

   int vectors = 0;
   int fails   = 0;
   bit done    = 0;

   always #4 clk = ~clk;

   conv_result_buffer #(.DATA_W(DW), .DEPTH(DP), .BYTE_W(8)) u0 (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_is_temp(wr_is_temp),
      .wr_data(wr_data), .rd_byte(rd_byte), .cs_fall(cs_fall),
      .rd_data(rd_data), .q_empty(q_empty), .q_full(q_full)
   );

   function automatic logic [DW-1:0] fv(int i);
      return DW'((i * 1237 + 91) % 4096);
   endfunction

   task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
      vectors++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %0h expected %0h", tag, got, exp);
      end
   endtask

   // All tasks start and end just after a falling edge.
   task automatic wr(bit t, logic [DW-1:0] v);
      wr_en = 1'b1; wr_is_temp = t; wr_data = v;
      @(negedge clk);
      wr_en = 1'b0; wr_is_temp = 1'b0;
   endtask

   task automatic rdb(output logic [7:0] b);
      b = rd_data;
      rd_byte = 1'b1;
      @(negedge clk);
      rd_byte = 1'b0;
   endtask

   task automatic csf();
      cs_fall = 1'b1;
      @(negedge clk);
      cs_fall = 1'b0;
   endtask

   task automatic rd_entry(string tag, logic [DW-1:0] v);
      logic [7:0] b;
      rdb(b); chk({tag, " hi"}, b, 32'(v >> 8));
      rdb(b); chk({tag, " lo"}, b, 32'(v[7:0]));
   endtask

   initial begin
      logic [7:0] b;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);

      // R1: reset state
      chk("R1 q_empty", q_empty, 1);
      chk("R1 q_full", q_full, 0);
      chk("R1 rd_data", rd_data, 0);

      // R6: read with nothing stored returns zero and moves nothing
      rdb(b); chk("R6 empty byte", b, 0);
      rdb(b); chk("R6 empty byte again", b, 0);
      wr(0, 12'hA5C);
      rd_entry("R6 pointer untouched", 12'hA5C);
      chk("R6 empty after", q_empty, 1);

      // R2 / R4: fill to depth, check flags, drain in order
      for (int i = 0; i < DP; i++) begin
         chk("R2 not full while filling", q_full, 0);
         wr(0, fv(i));
         chk("R2 not empty", q_empty, 0);
      end
      chk("R2 full at depth", q_full, 1);
      for (int i = 0; i < DP; i++) rd_entry("R2 R4 order", fv(i));
      chk("R2 empty after drain", q_empty, 1);

      // R3: overflow by 5 keeps the newest DEPTH results
      for (int i = 0; i < DP + 5; i++) wr(0, fv(i + 40));
      chk("R3 full after overflow", q_full, 1);
      for (int i = 5; i < DP + 5; i++) rd_entry("R3 oldest dropped", fv(i + 40));
      chk("R3 empty", q_empty, 1);

      // R5 / R9: high-byte read then chip-select edge re-reads the high byte
      wr(0, 12'h3C7); wr(0, 12'h812);
      rdb(b); chk("R5 first hi", b, 32'h03);
      csf();
      chk("R9 realigned hi", rd_data, 32'h03);
      rd_entry("R5 entry kept", 12'h3C7);
      rd_entry("R5 next entry", 12'h812);

      // R9: rd_byte in the same cycle as cs_fall is ignored
      wr(0, 12'h6E1);
      cs_fall = 1'b1; rd_byte = 1'b1;
      @(negedge clk);
      cs_fall = 1'b0; rd_byte = 1'b0;
      chk("R9 same-cycle read ignored", rd_data, 32'h06);
      rd_entry("R9 entry intact", 12'h6E1);

      // R7 / R8 / R11: temperature priority, replacement, sign passthrough
      wr(0, 12'h111); wr(0, 12'h222); wr(0, 12'h333);
      wr(1, 12'h0C8);
      wr(1, 12'hF38);
      rd_entry("R7 R8 R11 temperature first", 12'hF38);
      rd_entry("R8 voltage after temp", 12'h111);
      rd_entry("R8 voltage 2", 12'h222);
      rd_entry("R8 voltage 3", 12'h333);
      rdb(b); chk("R8 no second temp read", b, 0);

      // R7: temperature arriving while a voltage low byte is pending
      wr(0, 12'h4A4);
      rdb(b); chk("R7 volt hi", b, 32'h04);
      wr(1, 12'h7FF);
      rdb(b); chk("R7 volt lo finishes", b, 32'hA4);
      rd_entry("R7 temp next", 12'h7FF);
      chk("R7 empty", q_empty, 1);

      // R10: temperature overwritten while its low byte is pending
      wr(1, 12'h123);
      rdb(b); chk("R10 temp hi", b, 32'h01);
      wr(1, 12'hE07);
      rd_entry("R10 restart on new temp", 12'hE07);
      rdb(b); chk("R10 temp consumed", b, 0);

      // R10: head dropped by overflow while its low byte is pending
      for (int i = 0; i < DP; i++) wr(0, fv(100 + i));
      rdb(b); chk("R10 head hi", b, 32'(fv(100) >> 8));
      wr(0, fv(200));
      for (int i = 1; i < DP; i++) rd_entry("R10 after drop", fv(100 + i));
      rd_entry("R10 newest", fv(200));
      chk("R10 empty", q_empty, 1);

      // R1: reset mid-use clears everything
      wr(0, 12'h555); wr(1, 12'h666);
      rst = 1'b1; @(negedge clk); rst = 1'b0;
      chk("R1 reset empties queue", q_empty, 1);
      chk("R1 reset clears temp", rd_data, 0);

      // R2 / R4: sweep every 12-bit value through the queue
      for (int p = 0; p < 4096 / DP; p++) begin
         for (int k = 0; k < DP; k++) wr(0, DW'(p * DP + k));
         chk("R2 sweep full", q_full, 1);
         for (int k = 0; k < DP; k++) rd_entry("R4 sweep", DW'(p * DP + k));
      end
      chk("R2 sweep empty", q_empty, 1);

      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog (all requirements): got hung run expected completion");
         $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end
endmodule